// File: doc/BRIEF.md
# Late Physical Register Allocator with Youngest-Victim Stealing

This block hands out physical registers at the moment an instruction reaches its final execute cycle, not at decode. Each instruction carries a rename tag that names its result. The block holds the pool of free physical registers and a table that maps each tag to its physical register. When a request arrives and the pool has a free entry, the requester receives the lowest-numbered free register. The requester's tag is then mapped to that register.

When the pool is empty, the block looks at the reorder buffer window between the requester and the tail. It looks for instructions that have finished executing and whose tag still holds a physical register. The youngest of these loses its register to the requester. The block reports that victim's index and tag in the same cycle, so that the reorder buffer can clear its completion bit, the issue queue can mark it unissued, and its consumers can be told the operand is no longer ready. If there is no victim either, the requester is told to retry.

When an instruction commits, the register held by a superseded tag comes back through the release port. Only one request is served per cycle. The oldest requester wins.

Top module: `late_preg_alloc`

## Requirements
- R1: When at least one request is valid and the pool holds a free register, the winning requester is granted in the same cycle. `gnt_phys` is then the lowest-numbered free register, and that register is no longer free from the next cycle on.
- R2: Age is the distance (index − head) modulo the reorder buffer depth. Of all valid requests, only the one with the smallest age is granted. Every other valid request sees `retry` high in that cycle.
- R3: With the pool empty, only entries that meet all of these are victim candidates: the completion bit is set, the tag (taken from `rob_tag`) is currently mapped, and the age is strictly between the requester's age and the occupancy (tail − head modulo depth).
- R4: Among the candidates, the one with the largest age is chosen. `steal` is asserted, and `victim_idx` and `victim_tag` give that entry's index and tag, in the same cycle as the grant.
- R5: On a steal, `gnt_phys` equals the victim's mapped register. From the next cycle on, the requester's tag maps to that register and the victim's tag is unmapped.
- R6: If the pool is empty and there is no candidate, no grant is given. The winner sees `retry`, and the pool and table are unchanged.
- R7: A release of a mapped tag returns its register to the pool and unmaps the tag. A release of an unmapped tag has no effect.
- R8: After reset, every physical register is free and every tag is unmapped. With no request, `gnt` and `steal` are zero.
- R9: A completed entry that is older than or equal to the requester, or that lies outside the head-to-tail window, is never chosen as a victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | REQ_PORTS | Per-port allocation request |
| req_idx | input | REQ_PORTS*IDX_W | Reorder buffer index of each requester |
| req_tag | input | REQ_PORTS*TAG_W | Rename tag of each requester |
| rob_head | input | IDX_W | Oldest occupied reorder buffer entry |
| rob_tail | input | IDX_W | Next entry to be written; equal to head means empty |
| rob_done | input | ROB_DEPTH | Per-entry execution-complete bit |
| rob_tag | input | ROB_DEPTH*TAG_W | Per-entry rename tag |
| rel_valid | input | 1 | Commit-time release of a tag |
| rel_tag | input | TAG_W | Tag whose register is released |
| gnt | output | REQ_PORTS | Grant, one-hot or zero |
| retry | output | REQ_PORTS | Request not served this cycle |
| gnt_phys | output | PIDX_W | Physical register granted |
| steal | output | 1 | Grant was taken from a victim |
| victim_idx | output | IDX_W | Reorder buffer index of the victim |
| victim_tag | output | TAG_W | Tag of the victim, now not ready |

## Verification
The hardest state to reach is an empty pool that has a mix of candidates in the window. The mix needs completed-and-mapped entries, completed-but-unmapped entries, and completed entries older than the requester or beyond the tail, and it must hold while the window wraps past the end of the buffer. The stimulus table gets there in steps. It first drains the pool with grants. It then unmaps chosen tags through stealing and release. Finally it moves head and tail so that the window wraps, and only then issues the requests that must pick exactly one victim.

// File: rtl/lpa_pkg.sv
package lpa_pkg;
   typedef enum logic [1:0] {
      OUT_IDLE  = 2'd0,
      OUT_FREE  = 2'd1,
      OUT_STEAL = 2'd2,
      OUT_RETRY = 2'd3
   } lpa_outcome_e;
endpackage

// File: rtl/lpa_free_pool.sv
module lpa_free_pool #(
   parameter int PHYS_REGS = 4,
   localparam int PIDX_W = $clog2(PHYS_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [PIDX_W-1:0] take_idx,
   input  logic              put,
   input  logic [PIDX_W-1:0] put_idx,
   output logic [PHYS_REGS-1:0] free_mask,
   output logic              empty,
   output logic [PIDX_W-1:0] low_idx
);
   initial begin
      assert (PHYS_REGS >= 2) else $error("PHYS_REGS must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         free_mask <= '1;
      end else begin
         if (put)  free_mask[put_idx]  <= 1'b1;
         if (take) free_mask[take_idx] <= 1'b0;
      end
   end

   always_comb begin
      low_idx = '0;
      for (int i = PHYS_REGS - 1; i >= 0; i--) begin
         if (free_mask[i]) low_idx = PIDX_W'(i);
      end
   end

   assign empty = ~|free_mask;

   p_take_is_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> free_mask[take_idx]);
endmodule

// File: rtl/lpa_oldest_pick.sv
module lpa_oldest_pick #(
   parameter int PORTS = 2,
   parameter int IDX_W = 3,
   localparam int PW = (PORTS > 1) ? $clog2(PORTS) : 1
) (
   input  logic [PORTS-1:0]       req_valid,
   input  logic [PORTS*IDX_W-1:0] req_idx,
   input  logic [IDX_W-1:0]       head,
   output logic                   win_valid,
   output logic [PW-1:0]          win_port,
   output logic [IDX_W-1:0]       win_age
);
   logic [IDX_W-1:0] age [PORTS];

   for (genvar p = 0; p < PORTS; p++) begin : g_age
      assign age[p] = req_idx[p*IDX_W +: IDX_W] - head;
   end

   always_comb begin
      win_valid = 1'b0;
      win_port  = '0;
      win_age   = '0;
      for (int p = 0; p < PORTS; p++) begin
         if (req_valid[p] && (!win_valid || age[p] < win_age)) begin
            win_valid = 1'b1;
            win_port  = PW'(p);
            win_age   = age[p];
         end
      end
   end
endmodule

// File: rtl/lpa_victim_find.sv
module lpa_victim_find #(
   parameter int DEPTH = 8,
   parameter int TAGS  = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int TAG_W = $clog2(TAGS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [IDX_W-1:0]       head,
   input  logic [IDX_W-1:0]       tail,
   input  logic [IDX_W-1:0]       req_age,
   input  logic [DEPTH-1:0]       done,
   input  logic [DEPTH*TAG_W-1:0] tags,
   input  logic [TAGS-1:0]        mapped,
   output logic                   found,
   output logic [IDX_W-1:0]       vic_idx,
   output logic [TAG_W-1:0]       vic_tag
);
   logic [IDX_W-1:0] occ;
   logic [IDX_W-1:0] vic_age;
   logic [IDX_W-1:0] ent;
   logic [TAG_W-1:0] ent_tag;

   assign occ = tail - head;

   always_comb begin
      found   = 1'b0;
      vic_idx = '0;
      vic_tag = '0;
      vic_age = '0;
      ent     = '0;
      ent_tag = '0;
      for (int a = 1; a < DEPTH; a++) begin
         ent     = head + IDX_W'(a);
         ent_tag = tags[ent*TAG_W +: TAG_W];
         if (IDX_W'(a) > req_age && IDX_W'(a) < occ && done[ent] && mapped[ent_tag]) begin
            found   = 1'b1;
            vic_idx = ent;
            vic_tag = ent_tag;
            vic_age = IDX_W'(a);
         end
      end
   end

   p_victim_in_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> ((vic_idx - head) > req_age) && ((vic_idx - head) < occ));
   p_victim_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> done[vic_idx] && mapped[vic_tag] && (vic_age == vic_idx - head));
endmodule

// File: rtl/late_preg_alloc.sv
module late_preg_alloc #(
   parameter int ROB_DEPTH = 8,
   parameter int PHYS_REGS = 4,
   parameter int TAG_COUNT = 16,
   parameter int REQ_PORTS = 2,
   localparam int IDX_W  = $clog2(ROB_DEPTH),
   localparam int TAG_W  = $clog2(TAG_COUNT),
   localparam int PIDX_W = $clog2(PHYS_REGS),
   localparam int PW     = (REQ_PORTS > 1) ? $clog2(REQ_PORTS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [REQ_PORTS-1:0]       req_valid,
   input  logic [REQ_PORTS*IDX_W-1:0] req_idx,
   input  logic [REQ_PORTS*TAG_W-1:0] req_tag,
   input  logic [IDX_W-1:0]           rob_head,
   input  logic [IDX_W-1:0]           rob_tail,
   input  logic [ROB_DEPTH-1:0]       rob_done,
   input  logic [ROB_DEPTH*TAG_W-1:0] rob_tag,
   input  logic                       rel_valid,
   input  logic [TAG_W-1:0]           rel_tag,
   output logic [REQ_PORTS-1:0]       gnt,
   output logic [REQ_PORTS-1:0]       retry,
   output logic [PIDX_W-1:0]          gnt_phys,
   output logic                       steal,
   output logic [IDX_W-1:0]           victim_idx,
   output logic [TAG_W-1:0]           victim_tag
);
   import lpa_pkg::*;

   initial begin
      assert (ROB_DEPTH >= 2 && (ROB_DEPTH & (ROB_DEPTH - 1)) == 0)
         else $error("ROB_DEPTH must be a power of two");
      assert (TAG_COUNT >= ROB_DEPTH) else $error("TAG_COUNT too small");
      assert (REQ_PORTS >= 1) else $error("REQ_PORTS must be positive");
   end

   logic [TAG_COUNT-1:0] map_vld;
   logic [PIDX_W-1:0]    map_phys [TAG_COUNT];

   logic                 win_valid;
   logic [PW-1:0]        win_port;
   logic [IDX_W-1:0]     win_age;
   logic [TAG_W-1:0]     win_tag;

   logic                 found;
   logic [IDX_W-1:0]     vic_idx;
   logic [TAG_W-1:0]     vic_tag;

   logic [PHYS_REGS-1:0] free_mask;
   logic                 pool_empty;
   logic [PIDX_W-1:0]    low_idx;
   logic                 rel_hit;

   lpa_outcome_e         outcome;

   lpa_oldest_pick #(.PORTS(REQ_PORTS), .IDX_W(IDX_W)) u_pick (
      .req_valid (req_valid),
      .req_idx   (req_idx),
      .head      (rob_head),
      .win_valid (win_valid),
      .win_port  (win_port),
      .win_age   (win_age)
   );

   lpa_victim_find #(.DEPTH(ROB_DEPTH), .TAGS(TAG_COUNT)) u_find (
      .clk     (clk),
      .rst_n   (rst_n),
      .head    (rob_head),
      .tail    (rob_tail),
      .req_age (win_age),
      .done    (rob_done),
      .tags    (rob_tag),
      .mapped  (map_vld),
      .found   (found),
      .vic_idx (vic_idx),
      .vic_tag (vic_tag)
   );

   assign rel_hit = rel_valid && map_vld[rel_tag];

   lpa_free_pool #(.PHYS_REGS(PHYS_REGS)) u_pool (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (outcome == OUT_FREE),
      .take_idx  (low_idx),
      .put       (rel_hit),
      .put_idx   (map_phys[rel_tag]),
      .free_mask (free_mask),
      .empty     (pool_empty),
      .low_idx   (low_idx)
   );

   assign win_tag = req_tag[win_port*TAG_W +: TAG_W];

   always_comb begin
      if (!win_valid)       outcome = OUT_IDLE;
      else if (!pool_empty) outcome = OUT_FREE;
      else if (found)       outcome = OUT_STEAL;
      else                  outcome = OUT_RETRY;
   end

   for (genvar p = 0; p < REQ_PORTS; p++) begin : g_port
      assign gnt[p]   = (outcome == OUT_FREE || outcome == OUT_STEAL) && (win_port == PW'(p));
      assign retry[p] = req_valid[p] && !gnt[p];
   end

   always_comb begin
      case (outcome)
         OUT_FREE:  gnt_phys = low_idx;
         OUT_STEAL: gnt_phys = map_phys[vic_tag];
         default:   gnt_phys = '0;
      endcase
   end

   assign steal      = (outcome == OUT_STEAL);
   assign victim_idx = steal ? vic_idx : '0;
   assign victim_tag = steal ? vic_tag : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         map_vld <= '0;
         for (int t = 0; t < TAG_COUNT; t++) map_phys[t] <= '0;
      end else begin
         if (rel_hit) map_vld[rel_tag] <= 1'b0;
         if (outcome == OUT_FREE || outcome == OUT_STEAL) begin
            map_vld[win_tag]  <= 1'b1;
            map_phys[win_tag] <= gnt_phys;
         end
         if (outcome == OUT_STEAL) map_vld[vic_tag] <= 1'b0;
      end
   end

   p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   p_grant_when_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_valid && !pool_empty) |-> (|gnt && !steal));
   p_steal_only_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      steal |-> pool_empty);
   p_taken_not_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (|gnt && !steal) |=> !free_mask[$past(gnt_phys)]);
   p_victim_unmapped_r5: assert property (@(posedge clk) disable iff (!rst_n)
      steal |=> !map_vld[$past(victim_tag)]);
   p_retry_holds_pool_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_valid && ~|gnt && !rel_valid) |=> $stable(free_mask));
endmodule

// File: tb/tb_late_preg_alloc.sv
`timescale 1ns/1ps
module tb_late_preg_alloc;
   localparam int DEPTH = 8;
   localparam int NPHYS = 4;
   localparam int NTAGS = 16;
   localparam int PORTS = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  req_valid = '0;
   logic [5:0]  req_idx = '0;
   logic [7:0]  req_tag = '0;
   logic [2:0]  rob_head = '0;
   logic [2:0]  rob_tail = '0;
   logic [7:0]  rob_done = '0;
   logic [31:0] rob_tag;
   logic        rel_valid = 1'b0;
   logic [3:0]  rel_tag = '0;
   logic [1:0]  gnt;
   logic [1:0]  retry;
   logic [1:0]  gnt_phys;
   logic        steal;
   logic [2:0]  victim_idx;
   logic [3:0]  victim_tag;

   int checks = 0;
   int failures = 0;
   bit done_flag = 1'b0;

   always #2.5 clk = ~clk;

   for (genvar e = 0; e < DEPTH; e++) begin : g_tag
      assign rob_tag[e*4 +: 4] = 4'(e);
   end

   late_preg_alloc #(.ROB_DEPTH(DEPTH), .PHYS_REGS(NPHYS), .TAG_COUNT(NTAGS), .REQ_PORTS(PORTS)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx), .req_tag(req_tag),
      .rob_head(rob_head), .rob_tail(rob_tail), .rob_done(rob_done), .rob_tag(rob_tag),
      .rel_valid(rel_valid), .rel_tag(rel_tag), .gnt(gnt), .retry(retry), .gnt_phys(gnt_phys),
      .steal(steal), .victim_idx(victim_idx), .victim_tag(victim_tag)
   );

   typedef struct packed {
      logic [1:0] rv;
      logic [2:0] i0;
      logic [2:0] i1;
      logic [2:0] hd;
      logic [2:0] tl;
      logic [7:0] dn;
      logic       relv;
      logic [3:0] relt;
      logic [1:0] eg;
      logic [1:0] ep;
      logic       es;
      logic [2:0] ev;
   } row_t;

   localparam int NROWS = 16;
   localparam row_t ROWS [NROWS] = '{
      '{2'b01, 3'd2, 3'd0, 3'd0, 3'd7, 8'h00, 1'b0, 4'd0, 2'b01, 2'd0, 1'b0, 3'd0},
      '{2'b11, 3'd5, 3'd1, 3'd0, 3'd7, 8'h00, 1'b0, 4'd0, 2'b10, 2'd1, 1'b0, 3'd0},
      '{2'b01, 3'd6, 3'd0, 3'd0, 3'd7, 8'h00, 1'b0, 4'd0, 2'b01, 2'd2, 1'b0, 3'd0},
      '{2'b10, 3'd0, 3'd4, 3'd0, 3'd7, 8'h00, 1'b0, 4'd0, 2'b10, 2'd3, 1'b0, 3'd0},
      '{2'b01, 3'd3, 3'd0, 3'd0, 3'd7, 8'h56, 1'b0, 4'd0, 2'b01, 2'd2, 1'b1, 3'd6},
      '{2'b01, 3'd5, 3'd0, 3'd0, 3'd7, 8'h16, 1'b0, 4'd0, 2'b00, 2'd0, 1'b0, 3'd0},
      '{2'b01, 3'd0, 3'd0, 3'd0, 3'd3, 8'h16, 1'b0, 4'd0, 2'b01, 2'd0, 1'b1, 3'd2},
      '{2'b01, 3'd4, 3'd0, 3'd0, 3'd7, 8'h12, 1'b0, 4'd0, 2'b00, 2'd0, 1'b0, 3'd0},
      '{2'b00, 3'd0, 3'd0, 3'd0, 3'd7, 8'h00, 1'b1, 4'd1, 2'b00, 2'd0, 1'b0, 3'd0},
      '{2'b01, 3'd5, 3'd0, 3'd0, 3'd7, 8'h00, 1'b0, 4'd0, 2'b01, 2'd1, 1'b0, 3'd0},
      '{2'b00, 3'd0, 3'd0, 3'd0, 3'd7, 8'h00, 1'b1, 4'd6, 2'b00, 2'd0, 1'b0, 3'd0},
      '{2'b01, 3'd6, 3'd0, 3'd0, 3'd7, 8'h00, 1'b0, 4'd0, 2'b00, 2'd0, 1'b0, 3'd0},
      '{2'b00, 3'd0, 3'd0, 3'd0, 3'd7, 8'h00, 1'b1, 4'd3, 2'b00, 2'd0, 1'b0, 3'd0},
      '{2'b01, 3'd6, 3'd0, 3'd5, 3'd2, 8'h00, 1'b0, 4'd0, 2'b01, 2'd2, 1'b0, 3'd0},
      '{2'b01, 3'd7, 3'd0, 3'd5, 3'd2, 8'h23, 1'b0, 4'd0, 2'b01, 2'd0, 1'b1, 3'd0},
      '{2'b11, 3'd1, 3'd6, 3'd5, 3'd2, 8'h82, 1'b0, 4'd0, 2'b10, 2'd0, 1'b1, 3'd7}
   };

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] rv, input logic [2:0] i0, input logic [2:0] i1,
                        input logic [2:0] hd, input logic [2:0] tl, input logic [7:0] dn,
                        input logic relv, input logic [3:0] relt);
      @(negedge clk);
      req_valid = rv;
      req_idx   = {i1, i0};
      req_tag   = {1'b0, i1, 1'b0, i0};
      rob_head  = hd;
      rob_tail  = tl;
      rob_done  = dn;
      rel_valid = relv;
      rel_tag   = relt;
      #1;
   endtask

   initial begin
      #(100000);
      if (!done_flag) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      // R8: idle after reset
      drive(2'b00, 0, 0, 0, 7, 8'h00, 0, 0);
      rst_n = 1'b1;
      #0;
      check("R8", "gnt idle", int'(gnt), 0);
      check("R8", "steal idle", int'(steal), 0);

      // Table walk: R1 R2 R3 R4 R5 R6 R7 R9 in sequence
      for (int r = 0; r < NROWS; r++) begin
         drive(ROWS[r].rv, ROWS[r].i0, ROWS[r].i1, ROWS[r].hd, ROWS[r].tl,
               ROWS[r].dn, ROWS[r].relv, ROWS[r].relt);
         check($sformatf("R2 row%0d", r), "gnt", int'(gnt), int'(ROWS[r].eg));
         check($sformatf("R6 row%0d", r), "retry", int'(retry), int'(ROWS[r].rv & ~ROWS[r].eg));
         check($sformatf("R4 row%0d", r), "steal", int'(steal), int'(ROWS[r].es));
         if (ROWS[r].eg != 2'b00)
            check($sformatf("R1 R5 row%0d", r), "gnt_phys", int'(gnt_phys), int'(ROWS[r].ep));
         if (ROWS[r].es) begin
            check($sformatf("R4 R9 row%0d", r), "victim_idx", int'(victim_idx), int'(ROWS[r].ev));
            check($sformatf("R3 row%0d", r), "victim_tag", int'(victim_tag), int'(ROWS[r].ev));
         end
      end

      // R8: reset in mid-run restores a full pool
      drive(2'b00, 0, 0, 0, 7, 8'h00, 0, 0);
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      drive(2'b00, 0, 0, 0, 7, 8'h00, 0, 0);
      rst_n = 1'b1;
      #0;
      check("R8", "gnt after reset", int'(gnt), 0);
      for (int k = 0; k < NPHYS; k++) begin
         drive(2'b01, 3'(k), 0, 0, 7, 8'h00, 0, 0);
         check("R8 R1", "gnt after reset", int'(gnt), 1);
         check("R8 R1", "lowest free phys", int'(gnt_phys), k);
      end
      // R6: pool empty, nothing completed
      drive(2'b01, 3'd5, 0, 0, 7, 8'h00, 0, 0);
      check("R6", "retry when exhausted", int'(retry), 1);
      check("R6", "no steal", int'(steal), 0);

      drive(2'b00, 0, 0, 0, 7, 8'h00, 0, 0);
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule